// File: doc/BRIEF.md
# Audio Test Pattern Generator

This block produces multichannel audio test samples on a stream output with valid/ready handshaking, running on the audio clock. A programmable divider turns the audio clock into a sample-rate strobe, and each strobe starts one burst of beats, one beat per channel. The data is either an incrementing count or a sine tone taken from a small lookup table. The tone can be 1 kHz, 2 kHz, or 1 kHz on even (left) channels with 2 kHz on odd (right) channels. A programmable silence interval can mute the output periodically so that a tone becomes a beep.

Configuration is held on static inputs, and the surrounding logic changes it only while generation is off. In bypass mode the stream input drives the stream output directly, and bypass wins over generate-enable. The sequencing is a three-state machine. `ST_OFF` holds while generation is not running. `ST_WAIT` waits for the sample strobe, and the strobe moves it to `ST_SEND` while snapshotting the pattern state. `ST_SEND` presents one beat per channel and returns to `ST_WAIT` after the last channel's handshake. From any state, dropping out of the running condition returns the machine to `ST_OFF`.

Top module: `audio_pattern_gen`

## Requirements
- R1: When `cfg_bypass` is 1, `m_tdata`, `m_tid` and `m_tvalid` equal `s_tdata`, `s_tid` and `s_tvalid`, and `s_tready` equals `m_tready`, in the same cycle and whatever `cfg_enable` is.
- R2: When `cfg_bypass` is 0 and `cfg_enable` is 0, `m_tvalid` and `s_tready` are 0. This is also the state right after reset with those inputs.
- R3: Counting the first running cycle (enable 1, bypass 0) as t=0, a strobe occurs in every cycle with t mod M = M-1, where M is `cfg_mult`. `m_tvalid` rises in the cycle after the strobe. A strobe that comes while a burst is still being sent starts no burst.
- R4: A burst carries `cfg_chans` beats (2, 4, 6 or 8) with `m_tid` values 0, 1, ..., N-1 in ascending order. `m_tvalid` falls after the handshake of beat N-1.
- R5: While `m_tvalid` is 1 and `m_tready` is 0, `m_tdata` and `m_tid` hold their values into the next cycle.
- R6: Pattern code 7 gives an incrementing count. The burst started by strobe k (k=1,2,...) carries the value k-1 modulo 2^width on every channel.
- R7: Width code 1 places a 16-bit sample in `m_tdata[15:0]`, code 2 a 20-bit sample in `[19:0]`, and code 4 a 24-bit sample in `[23:0]`. Unused upper bits are 0. A 16-bit tone value is shifted left by 0, 4 or 8 bits to fill the width.
- R8: Pattern code 0 gives a 1 kHz tone and code 1 a 2 kHz tone on all channels. The 16-bit phase for burst k is (k-1)*S mod 65536, with S=2048, 1486 or 1365 for rate codes 0, 1 and 2 (32, 44.1 and 48 kHz), doubled for 2 kHz. The tone value is round(32767*sin(2*pi*i/64)), where i is the top 6 bits of the phase.
- R9: Pattern code 2 puts the 1 kHz tone on even channel IDs and the 2 kHz tone on odd channel IDs.
- R10: With silence value V > 0, the running cycles alternate between 2V-cycle tone phases and 2V-cycle silent phases, starting with tone. A burst whose strobe falls in a silent phase carries 0 on every channel. V=0 never mutes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Generate enable |
| cfg_bypass | input | 1 | Bypass, overrides enable |
| cfg_mult | input | 16 | Audio clocks per sample period |
| cfg_chans | input | 8 | Channel count (2, 4, 6, 8) |
| cfg_width | input | 3 | Sample width code |
| cfg_pattern | input | 3 | Pattern code |
| cfg_rate | input | 2 | Sample-rate code for tone steps |
| cfg_silence | input | 16 | Silence interval value |
| s_tdata | input | 24 | Stream input data |
| s_tid | input | 3 | Stream input channel ID |
| s_tvalid | input | 1 | Stream input valid |
| s_tready | output | 1 | Stream input ready |
| m_tdata | output | 24 | Stream output data |
| m_tid | output | 3 | Stream output channel ID |
| m_tvalid | output | 1 | Stream output valid |
| m_tready | input | 1 | Stream output ready |

## Verification
Bypass and the disabled state act within the cycle, so those results are compared in the same cycle the inputs are applied. A burst's first beat is due one cycle after its strobe cycle, and each later beat is due one cycle after the previous beat's handshake. The bench model counts running cycles from t=0 to place every strobe, queues a burst's expected beats in the strobe cycle, and compares the queue head against the outputs at each falling edge. That sampling point lies one register stage after the strobe. The model also takes the mute decision from the strobe cycle, and it drops a strobe whenever the queue was still non-empty before that cycle's pop.

// File: rtl/apg_pkg.sv
package apg_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT,
        ST_SEND
    } apg_state_e;

    localparam int TONE_W  = 16;
    localparam int PHASE_W = 16;
    localparam int LUT_AW  = 6;

    // quarter-wave magnitude, 17 points from 0 to pi/2, full scale 32767
    function automatic logic [TONE_W-1:0] apg_quarter(input logic [4:0] k);
        logic [TONE_W-1:0] m;
        unique case (k)
            5'd0:  m = 16'd0;
            5'd1:  m = 16'd3212;
            5'd2:  m = 16'd6393;
            5'd3:  m = 16'd9512;
            5'd4:  m = 16'd12539;
            5'd5:  m = 16'd15446;
            5'd6:  m = 16'd18204;
            5'd7:  m = 16'd20787;
            5'd8:  m = 16'd23170;
            5'd9:  m = 16'd25329;
            5'd10: m = 16'd27245;
            5'd11: m = 16'd28898;
            5'd12: m = 16'd30273;
            5'd13: m = 16'd31356;
            5'd14: m = 16'd32137;
            5'd15: m = 16'd32609;
            default: m = 16'd32767;
        endcase
        return m;
    endfunction

    // full cycle of 64 points built from the quarter wave by symmetry
    function automatic logic [TONE_W-1:0] apg_sine(input logic [LUT_AW-1:0] idx);
        logic [4:0]        k;
        logic [TONE_W-1:0] mag;
        k   = idx[4] ? (5'd16 - {1'b0, idx[3:0]}) : {1'b0, idx[3:0]};
        mag = apg_quarter(k);
        return idx[5] ? (~mag + 16'd1) : mag;
    endfunction

    // phase step for 1 kHz at the selected rate: 65536 * 1000 / Fs
    function automatic logic [PHASE_W-1:0] apg_step(input logic [1:0] rate);
        logic [PHASE_W-1:0] s;
        unique case (rate)
            2'd0:    s = 16'd2048;
            2'd1:    s = 16'd1486;
            default: s = 16'd1365;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/apg_rate_timer.sv
module apg_rate_timer #(
    parameter int MULT_W = 16,
    parameter int SIL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [MULT_W-1:0] mult,
    input  logic [SIL_W-1:0]  silence,
    output logic              tick,
    output logic              silent
);

    localparam int SCNT_W = SIL_W + 1;

    logic [MULT_W-1:0] cnt;
    logic [MULT_W-1:0] cnt_last;
    logic [SCNT_W-1:0] scnt;
    logic [SCNT_W-1:0] scnt_last;

    assign cnt_last  = (mult == '0) ? '0 : mult - 1'b1;
    assign scnt_last = {silence, 1'b0} - 1'b1;
    assign tick      = run && (cnt >= cnt_last);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt >= cnt_last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run || (silence == '0)) begin
            scnt   <= '0;
            silent <= 1'b0;
        end else if (scnt >= scnt_last) begin
            scnt   <= '0;
            silent <= ~silent;
        end else begin
            scnt <= scnt + 1'b1;
        end
    end

    // R3: strobes are at least a full period apart when the period exceeds one cycle
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (mult > 16'd1) && $stable(mult)) |=> !tick)
        else $error("tick repeated within one sample period");

    // R10: a zero silence value never mutes
    assert_no_mute_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (silence == '0) |=> !silent)
        else $error("muted with zero silence value");

endmodule

// File: rtl/apg_stream_fsm.sv
module apg_stream_fsm
    import apg_pkg::*;
#(
    parameter int ID_W  = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] chans,
    input  logic             ready,
    output logic             valid,
    output logic             load,
    output logic [ID_W-1:0]  ch
);

    localparam int MAX_CH = 1 << ID_W;

    apg_state_e       state;
    apg_state_e       state_nx;
    logic [CNT_W-1:0] n_eff;
    logic [ID_W-1:0]  ch_last;
    logic             beat_done;

    always_comb begin
        if (chans < CNT_W'(2)) begin
            n_eff = CNT_W'(2);
        end else if (chans > CNT_W'(MAX_CH)) begin
            n_eff = CNT_W'(MAX_CH);
        end else begin
            n_eff = chans;
        end
    end

    assign ch_last   = ID_W'(n_eff - 1'b1);
    assign beat_done = (state == ST_SEND) && ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (run) state_nx = ST_WAIT;
            ST_WAIT: if (!run) state_nx = ST_OFF;
                     else if (tick) state_nx = ST_SEND;
            ST_SEND: if (!run) state_nx = ST_OFF;
                     else if (beat_done && (ch == ch_last)) state_nx = ST_WAIT;
            default: state_nx = ST_OFF;
        endcase
    end

    // outputs
    assign valid = (state == ST_SEND);
    assign load  = (state == ST_WAIT) && run && tick;

    always_ff @(posedge clk) begin
        if (!rst_n || (state != ST_SEND)) begin
            ch <= '0;
        end else if (beat_done) begin
            ch <= (ch == ch_last) ? '0 : ch + 1'b1;
        end
    end

    // R4: channel IDs advance by one per accepted beat inside a burst
    assert_id_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && beat_done && (ch != ch_last) && $stable(chans)) |=> (run -> (ch == $past(ch) + 1'b1)))
        else $error("channel ID did not advance by one");

    // R2: leaving the running condition ends any burst
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !valid)
        else $error("burst continued after generation stopped");

endmodule

// File: rtl/apg_pattern.sv
module apg_pattern
    import apg_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              load,
    input  logic              silent,
    input  logic [2:0]        pattern,
    input  logic [1:0]        rate,
    input  logic [2:0]        width,
    input  logic [ID_W-1:0]   ch,
    output logic [DATA_W-1:0] data
);

    localparam int PAD8 = DATA_W - TONE_W - 8;
    localparam int PAD4 = DATA_W - TONE_W - 4;
    localparam int PAD0 = DATA_W - TONE_W;

    logic [DATA_W-1:0]  inc_live;
    logic [PHASE_W-1:0] ph_lo;
    logic [PHASE_W-1:0] ph_hi;
    logic [PHASE_W-1:0] step;

    logic [DATA_W-1:0]  inc_snap;
    logic [PHASE_W-1:0] ph_lo_snap;
    logic [PHASE_W-1:0] ph_hi_snap;
    logic               mute_snap;

    logic [PHASE_W-1:0] ph_sel;
    logic [TONE_W-1:0]  tone;
    logic [DATA_W-1:0]  tone_fmt;
    logic [DATA_W-1:0]  inc_fmt;

    assign step = apg_step(rate);

    // live pattern state advances on every strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            inc_live <= '0;
            ph_lo    <= '0;
            ph_hi    <= '0;
        end else if (tick) begin
            inc_live <= inc_live + 1'b1;
            ph_lo    <= ph_lo + step;
            ph_hi    <= ph_hi + {step[PHASE_W-2:0], 1'b0};
        end
    end

    // snapshot for the burst being sent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_snap   <= '0;
            ph_lo_snap <= '0;
            ph_hi_snap <= '0;
            mute_snap  <= 1'b0;
        end else if (load) begin
            inc_snap   <= inc_live;
            ph_lo_snap <= ph_lo;
            ph_hi_snap <= ph_hi;
            mute_snap  <= silent;
        end
    end

    always_comb begin
        unique case (pattern)
            3'd1:    ph_sel = ph_hi_snap;
            3'd2:    ph_sel = ch[0] ? ph_hi_snap : ph_lo_snap;
            default: ph_sel = ph_lo_snap;
        endcase
    end

    assign tone = apg_sine(ph_sel[PHASE_W-1 -: LUT_AW]);

    always_comb begin
        unique case (width)
            3'd1: begin
                tone_fmt = {{PAD0{1'b0}}, tone};
                inc_fmt  = {{PAD0{1'b0}}, inc_snap[TONE_W-1:0]};
            end
            3'd2: begin
                tone_fmt = {{PAD4{1'b0}}, tone, 4'b0};
                inc_fmt  = {{PAD4{1'b0}}, inc_snap[TONE_W+3:0]};
            end
            default: begin
                tone_fmt = {{PAD8{1'b0}}, tone, 8'b0};
                inc_fmt  = inc_snap;
            end
        endcase
    end

    always_comb begin
        if (mute_snap) begin
            data = '0;
        end else if (pattern == 3'd7) begin
            data = inc_fmt;
        end else if (pattern <= 3'd2) begin
            data = tone_fmt;
        end else begin
            data = '0;
        end
    end

    // R6: the live count steps by exactly one per strobe
    assert_inc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (!run || (inc_live == $past(inc_live) + 1'b1)))
        else $error("incrementing count skipped");

endmodule

// File: rtl/audio_pattern_gen.sv
module audio_pattern_gen
    import apg_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ID_W   = 3,
    parameter int MULT_W = 16,
    parameter int SIL_W  = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_bypass,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic [CNT_W-1:0]  cfg_chans,
    input  logic [2:0]        cfg_width,
    input  logic [2:0]        cfg_pattern,
    input  logic [1:0]        cfg_rate,
    input  logic [SIL_W-1:0]  cfg_silence,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [ID_W-1:0]   s_tid,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic [ID_W-1:0]   m_tid,
    output logic              m_tvalid,
    input  logic              m_tready
);

    logic              run;
    logic              tick;
    logic              silent;
    logic              gen_valid;
    logic              gen_load;
    logic [ID_W-1:0]   gen_ch;
    logic [DATA_W-1:0] gen_data;

    assign run = cfg_enable && !cfg_bypass;

    apg_rate_timer #(
        .MULT_W (MULT_W),
        .SIL_W  (SIL_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .mult    (cfg_mult),
        .silence (cfg_silence),
        .tick    (tick),
        .silent  (silent)
    );

    apg_stream_fsm #(
        .ID_W  (ID_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .chans (cfg_chans),
        .ready (m_tready),
        .valid (gen_valid),
        .load  (gen_load),
        .ch    (gen_ch)
    );

    apg_pattern #(
        .DATA_W (DATA_W),
        .ID_W   (ID_W)
    ) u_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .load    (gen_load),
        .silent  (silent),
        .pattern (cfg_pattern),
        .rate    (cfg_rate),
        .width   (cfg_width),
        .ch      (gen_ch),
        .data    (gen_data)
    );

    // bypass wins over generation
    always_comb begin
        if (cfg_bypass) begin
            m_tdata  = s_tdata;
            m_tid    = s_tid;
            m_tvalid = s_tvalid;
            s_tready = m_tready;
        end else begin
            m_tdata  = gen_data;
            m_tid    = gen_ch;
            m_tvalid = run && gen_valid;
            s_tready = 1'b0;
        end
    end

    // R5: a stalled beat keeps its data and ID
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && m_tvalid && !m_tready) |=>
            (!run || !$stable(cfg_pattern) || (m_tvalid && $stable(m_tdata) && $stable(m_tid))))
        else $error("stalled beat changed");

    // R4: a burst opens on channel 0
    assert_first_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $rose(gen_valid)) |-> (m_tid == '0))
        else $error("burst did not start on channel 0");

endmodule

// File: tb/audio_pattern_gen_bench.sv
module audio_pattern_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_bypass = 1'b1;
    logic [15:0] cfg_mult = 16'd384;
    logic [7:0]  cfg_chans = 8'd2;
    logic [2:0]  cfg_width = 3'd4;
    logic [2:0]  cfg_pattern = 3'd0;
    logic [1:0]  cfg_rate = 2'd2;
    logic [15:0] cfg_silence = 16'd0;
    logic [23:0] s_tdata = '0;
    logic [2:0]  s_tid = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [23:0] m_tdata;
    logic [2:0]  m_tid;
    logic        m_tvalid;
    logic        m_tready = 1'b1;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    bit finished = 1'b0;
    bit rand_ready = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [23:0] q_data[$];
    int          q_id[$];
    string       q_tag[$];
    int          t = 0;
    bit          was_stall = 1'b0;
    logic [23:0] stall_data;
    logic [2:0]  stall_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_pattern_gen u_audio_pattern_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(cfg_enable), .cfg_bypass(cfg_bypass), .cfg_mult(cfg_mult),
        .cfg_chans(cfg_chans), .cfg_width(cfg_width), .cfg_pattern(cfg_pattern),
        .cfg_rate(cfg_rate), .cfg_silence(cfg_silence),
        .s_tdata(s_tdata), .s_tid(s_tid), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tid(m_tid), .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_tone(input int idx);
        real v;
        v = 32767.0 * $sin(2.0 * 3.14159265358979 * idx / 64.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic int width_bits(input logic [2:0] code);
        if (code == 3'd1) return 16;
        if (code == 3'd2) return 20;
        return 24;
    endfunction

    // expected value of channel c in the burst of sample index n
    function automatic logic [23:0] ref_sample(input int n, input int c, input bit mute);
        int w;
        int step;
        int ph;
        int v;
        longint mask;
        w = width_bits(cfg_width);
        mask = (64'd1 << w) - 1;
        step = (cfg_rate == 2'd0) ? 2048 : (cfg_rate == 2'd1) ? 1486 : 1365;
        if (mute) return 24'd0;
        if (cfg_pattern == 3'd7) return 24'(longint'(n) & mask);
        if (cfg_pattern > 3'd2) return 24'd0;
        if (cfg_pattern == 3'd1 || (cfg_pattern == 3'd2 && (c % 2) == 1)) step = step * 2;
        ph = (n * step) % 65536;
        v = ref_tone(ph / 1024);
        return 24'((longint'(v) <<< (w - 16)) & mask);
    endfunction

    // stimulus for the upstream side and the output ready
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s_tdata = {lfsr[7:0], lfsr};
            s_tid = lfsr[10:8];
            s_tvalid = lfsr[3];
            m_tready = rand_ready ? (lfsr[1] | lfsr[6]) : 1'b1;
        end
    end

    // behavioural reference, compared every cycle at the falling edge
    always @(negedge clk) begin
        if (model_on) begin
            if (cfg_bypass) begin
                check(m_tdata == s_tdata && m_tid == s_tid && m_tvalid == s_tvalid,
                      "R1 forward", {m_tvalid, m_tid, m_tdata}, {s_tvalid, s_tid, s_tdata});
                check(s_tready == m_tready, "R1 ready", s_tready, m_tready);
                q_data.delete(); q_id.delete(); q_tag.delete();
                t = 0; was_stall = 1'b0;
            end else if (!cfg_enable) begin
                check(!m_tvalid && !s_tready, "R2 idle", {m_tvalid, s_tready}, 0);
                q_data.delete(); q_id.delete(); q_tag.delete();
                t = 0; was_stall = 1'b0;
            end else begin
                bit busy;
                busy = (q_data.size() > 0);
                check(m_tvalid == busy, "R3 valid timing", m_tvalid, busy);
                if (was_stall && m_tvalid)
                    check(m_tdata == stall_data && m_tid == stall_id, "R5 hold",
                          {m_tid, m_tdata}, {stall_id, stall_data});
                if (busy && m_tvalid) begin
                    check(m_tid == q_id[0], "R4 channel id", m_tid, q_id[0]);
                    check(m_tdata == q_data[0], q_tag[0], m_tdata, q_data[0]);
                end
                was_stall = m_tvalid && !m_tready;
                stall_data = m_tdata;
                stall_id = m_tid;
                if (busy && m_tvalid && m_tready) begin
                    void'(q_data.pop_front()); void'(q_id.pop_front()); void'(q_tag.pop_front());
                end
                if ((t % int'(cfg_mult)) == int'(cfg_mult) - 1 && !busy) begin
                    int n;
                    bit mute;
                    string tag;
                    n = t / int'(cfg_mult);
                    mute = (cfg_silence != 0) && (((t / (2 * int'(cfg_silence))) % 2) == 1);
                    if (mute) tag = "R10 muted data";
                    else if (cfg_pattern == 3'd7) tag = "R6 R7 count data";
                    else if (cfg_pattern == 3'd2) tag = "R9 R7 split tone data";
                    else tag = "R8 R7 tone data";
                    for (int c = 0; c < int'(cfg_chans); c++) begin
                        q_data.push_back(ref_sample(n, c, mute));
                        q_id.push_back(c);
                        q_tag.push_back(tag);
                    end
                end
                t++;
            end
        end
    end

    task automatic apply(input bit en, input bit byp, input int mult, input int chans,
                         input int wcode, input int pat, input int rate, input int sil,
                         input bit rr, input int cycles);
        @(posedge clk); #1;
        cfg_enable = 1'b0; cfg_bypass = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        cfg_mult = 16'(mult); cfg_chans = 8'(chans); cfg_width = 3'(wcode);
        cfg_pattern = 3'(pat); cfg_rate = 2'(rate); cfg_silence = 16'(sil);
        rand_ready = rr;
        cfg_enable = en; cfg_bypass = byp;
        repeat (cycles) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        cfg_bypass = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state with generation off and bypass off
        check(!m_tvalid && !s_tready, "R2 reset state", {m_tvalid, s_tready}, 0);
        model_on = 1'b1;
        // R1 bypass overrides enable
        apply(1'b1, 1'b1, 10, 2, 4, 7, 2, 0, 1'b1, 60);
        // R2 disabled
        apply(1'b0, 1'b0, 10, 2, 4, 7, 2, 0, 1'b1, 30);
        // R6 R3 incrementing count, 24-bit, 2 channels, steady ready
        apply(1'b1, 1'b0, 10, 2, 4, 7, 2, 0, 1'b0, 400);
        // R6 R7 R5 count at 16-bit, 4 channels, stalling ready
        apply(1'b1, 1'b0, 12, 4, 1, 7, 0, 0, 1'b1, 600);
        // R8 1 kHz at 48 kHz, 24-bit, over more than one tone cycle
        apply(1'b1, 1'b0, 24, 4, 4, 0, 2, 0, 1'b1, 24 * 70);
        // R8 R7 2 kHz at 32 kHz, 20-bit, 6 channels
        apply(1'b1, 1'b0, 20, 6, 2, 1, 0, 0, 1'b1, 20 * 40);
        // R9 split tones at 44.1 kHz, 16-bit, 8 channels
        apply(1'b1, 1'b0, 40, 8, 1, 2, 1, 0, 1'b1, 40 * 50);
        // R3 strobes dropped while a slow burst is still being sent
        apply(1'b1, 1'b0, 6, 8, 4, 7, 2, 0, 1'b1, 300);
        // R10 silence gating of the count pattern
        apply(1'b1, 1'b0, 16, 2, 4, 7, 2, 50, 1'b0, 1200);
        // R10 silence gating of a tone, short interval
        apply(1'b1, 1'b0, 8, 2, 4, 0, 2, 7, 1'b1, 600);
        // R1 bypass after running
        apply(1'b1, 1'b1, 8, 2, 4, 0, 2, 0, 1'b1, 40);
        model_on = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule